// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a two-channel serial audio stream into parallel sample words. It receives a bit clock, a left/right clock, a word clock and a serial data line. A much faster system clock (at least four times the bit clock) oversamples all four lines, and the block acts only on the bit clock transitions it detects. The block therefore accepts a bit clock that is gated or bursty and may rest at either level between fields.

Static pins choose one of four framing formats and the active bit clock edge. An input sets the word length, from 4 to 16 bits, and the block latches it at the start of each field. Each finished channel word appears left-aligned on a 16-bit output. A one-cycle strobe marks each completed left/right frame, so a downstream sample FIFO or mixer can take both words in the strobe cycle.

Top module: `sar_receiver`

## Requirements
- R1: While `rst` is high, and after it falls until the first field is stored, `left_word` and `right_word` read zero and `frame_valid` stays low.
- R2: With `fmt_sel` = 2'b00, a field starts at the first active bit clock edge where the sampled left/right clock differs from its value at the previous active edge, and the MSB is taken at that same edge. A high left/right level means the left channel and a low level means the right channel.
- R3: With `fmt_sel` = 2'b01, the framing of R2 applies, but the MSB is taken one active edge after the edge where the field starts.
- R4: With `fmt_sel` = 2'b10, the framing of R2 applies, but the MSB is taken 16 active edges after the edge where the field starts.
- R5: With `fmt_sel` = 2'b11, a field starts at the first active edge where the word clock is sampled high after it was sampled low at the previous active edge. The MSB is taken at that edge, and the left/right level sampled there picks the channel. The falling time of the word clock has no effect.
- R6: With `bclk_pol` = 0, the active edge is the rising bit clock edge. With `bclk_pol` = 1, it is the falling edge.
- R7: The word length is `word_len` clamped to 4..16 and latched at field start. Bits after the last counted bit have no effect. A stored word holds the MSB in bit 15 and zeros below its length.
- R8: If a new field starts before the current field has all its bits, the current field is stored with its missing low bits set to zero.
- R9: `frame_valid` pulses for exactly one system clock each time a right word is stored. `right_word` changes only in a cycle where `frame_valid` is high.
- R10: The bit clock may pause between edges and rest at either level. Fields may also follow each other with no gap, as in a 32-edge frame that carries two 16-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock, may be gated |
| lrclk_in | input | 1 | Left/right channel clock |
| wclk_in | input | 1 | Word clock, used in format 2'b11 only |
| sdata_in | input | 1 | Serial data, MSB first, two's complement |
| fmt_sel | input | 2 | Framing format select |
| bclk_pol | input | 1 | Active bit clock edge select |
| word_len | input | 5 | Requested word length |
| left_word | output | 16 | Last stored left word, left-aligned |
| right_word | output | 16 | Last stored right word, left-aligned |
| frame_valid | output | 1 | One-cycle pulse on each stored right word |

## Verification
The bench builds the receiver with its default two-stage synchronizer and 16-bit sample width. With these values, fields of up to 64 active edges are long enough to exercise the full 16-bit delay of the right-justified format together with a 16-bit word. Short word lengths and clamped requests produce fields that run past the counted bits. The default synchronizer depth lets the bench hold each bit clock phase for four system clocks, so it can also insert random pauses and random idle levels between edges.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned LEN_W    = $clog2(SAMPLE_W + 1);
    localparam int unsigned IDX_W    = $clog2(SAMPLE_W);
    localparam int unsigned MIN_LEN  = 4;
    localparam int unsigned RJ_GAP   = 16;
    localparam int unsigned POS_W    = $clog2(RJ_GAP + SAMPLE_W + 1);

    // fmt_sel encoding, {first select, second select}
    typedef enum logic [1:0] {
        FMT_LJ     = 2'b00,
        FMT_LJ_DLY = 2'b01,
        FMT_RJ16   = 2'b10,
        FMT_WCLK   = 2'b11
    } fmt_e;

    typedef enum logic {
        CH_RIGHT = 1'b0,
        CH_LEFT  = 1'b1
    } chan_e;

    // line levels captured at an active bit clock edge
    typedef struct packed {
        logic lr;
        logic wc;
        logic sd;
    } line_t;

    // per-edge event from framer to assembler
    typedef struct packed {
        logic             start;
        logic             cut;
        chan_e            cut_ch;
        logic             bit_we;
        logic [IDX_W-1:0] idx;
        logic             bit_val;
        logic             full;
        chan_e            ch;
    } field_ev_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] req);
        if (req < LEN_W'(MIN_LEN))       return LEN_W'(MIN_LEN);
        else if (req > LEN_W'(SAMPLE_W)) return LEN_W'(SAMPLE_W);
        else                             return req;
    endfunction

    function automatic logic [POS_W-1:0] lead_bits(input fmt_e f);
        case (f)
            FMT_LJ_DLY: return POS_W'(1);
            FMT_RJ16:   return POS_W'(RJ_GAP);
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sar_edge.sv
module sar_edge (
    input  logic clk,
    input  logic rst,
    input  logic pol,
    input  logic bclk_s,
    output logic tick
);

    logic bclk_d;
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            seen_q <= 1'b1;
        end
    end

    // a transition into the level that the polarity marks as active
    always_comb begin
        tick = seen_q && (bclk_s != bclk_d) && (bclk_s == !pol);
    end

endmodule

// File: rtl/sar_framer.sv
module sar_framer
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  line_t            samp,
    input  fmt_e             fmt,
    input  logic [LEN_W-1:0] len_req,
    output field_ev_t        ev,
    output logic [LEN_W-1:0] len_now
);

    logic             primed_q;
    logic             lr_q;
    logic             wc_q;
    logic             active_q;
    logic             done_q;
    chan_e            ch_q;
    logic [POS_W-1:0] pos_q;
    logic [LEN_W-1:0] len_q;

    logic             start;
    logic             in_win;
    logic             last;
    logic [POS_W-1:0] pos_now;
    logic [POS_W-1:0] lead;
    logic [POS_W-1:0] rel;

    always_comb begin
        lead = lead_bits(fmt);
        if (fmt == FMT_WCLK) start = tick && primed_q && samp.wc && !wc_q;
        else                 start = tick && primed_q && (samp.lr != lr_q);

        pos_now = start ? '0 : pos_q;
        len_now = start ? clamp_len(len_req) : len_q;
        rel     = pos_now - lead;
        in_win  = tick && (start || (active_q && !done_q))
                  && (pos_now >= lead) && (rel < POS_W'(len_now));
        last    = in_win && (rel == (POS_W'(len_now) - POS_W'(1)));

        ev.start   = start;
        ev.cut     = start && active_q && !done_q;
        ev.cut_ch  = ch_q;
        ev.bit_we  = in_win;
        ev.idx     = rel[IDX_W-1:0];
        ev.bit_val = samp.sd;
        ev.full    = last;
        ev.ch      = start ? chan_e'(samp.lr) : ch_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q <= 1'b0;
            lr_q     <= 1'b0;
            wc_q     <= 1'b0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
            ch_q     <= CH_RIGHT;
            pos_q    <= '0;
            len_q    <= LEN_W'(SAMPLE_W);
        end else if (tick) begin
            primed_q <= 1'b1;
            lr_q     <= samp.lr;
            wc_q     <= samp.wc;
            if (start) begin
                active_q <= 1'b1;
                ch_q     <= ev.ch;
                len_q    <= len_now;
                done_q   <= last;
                pos_q    <= POS_W'(1);
            end else if (active_q) begin
                done_q <= done_q | last;
                if (pos_q != '1) pos_q <= pos_q + POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/sar_assembler.sv
module sar_assembler
    import sar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  field_ev_t           ev,
    output logic [SAMPLE_W-1:0] left_q,
    output logic [SAMPLE_W-1:0] right_q,
    output logic                strobe
);

    logic [SAMPLE_W-1:0] acc_q;
    logic [SAMPLE_W-1:0] acc_base;
    logic [SAMPLE_W-1:0] acc_nx;
    logic [SAMPLE_W-1:0] mask;

    always_comb begin
        acc_base = ev.start ? '0 : acc_q;
        mask     = {1'b1, {(SAMPLE_W-1){1'b0}}} >> ev.idx;
        acc_nx   = acc_base;
        if (ev.bit_we) acc_nx = ev.bit_val ? (acc_base | mask) : (acc_base & ~mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            left_q  <= '0;
            right_q <= '0;
            strobe  <= 1'b0;
        end else begin
            acc_q <= acc_nx;
            if (ev.cut) begin
                if (ev.cut_ch == CH_LEFT) left_q  <= acc_q;
                else                      right_q <= acc_q;
            end
            if (ev.full) begin
                if (ev.ch == CH_LEFT) left_q  <= acc_nx;
                else                  right_q <= acc_nx;
            end
            strobe <= (ev.cut && ev.cut_ch == CH_RIGHT) || (ev.full && ev.ch == CH_RIGHT);
        end
    end

endmodule

// File: rtl/sar_receiver.sv
module sar_receiver
    import sar_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_in,
    input  logic                lrclk_in,
    input  logic                wclk_in,
    input  logic                sdata_in,
    input  logic [1:0]          fmt_sel,
    input  logic                bclk_pol,
    input  logic [LEN_W-1:0]    word_len,
    output logic [SAMPLE_W-1:0] left_word,
    output logic [SAMPLE_W-1:0] right_word,
    output logic                frame_valid
);

    localparam int unsigned LINES = 4;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             bclk_s;
    line_t            samp;
    logic             tick;
    field_ev_t        ev;
    logic [LEN_W-1:0] cur_wl;
    logic             bit_we;
    logic [IDX_W-1:0] bit_idx;

    assign raw     = {bclk_in, lrclk_in, wclk_in, sdata_in};
    assign bclk_s  = synced[3];
    assign samp    = '{lr: synced[2], wc: synced[1], sd: synced[0]};
    assign bit_we  = ev.bit_we;
    assign bit_idx = ev.idx;

    sar_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    sar_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .pol    (bclk_pol),
        .bclk_s (bclk_s),
        .tick   (tick)
    );

    sar_framer u_framer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .samp    (samp),
        .fmt     (fmt_e'(fmt_sel)),
        .len_req (word_len),
        .ev      (ev),
        .len_now (cur_wl)
    );

    sar_assembler u_asm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .left_q  (left_word),
        .right_q (right_word),
        .strobe  (frame_valid)
    );

endmodule

// File: rtl/sar_checker.sv
module sar_checker
    import sar_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                frame_valid,
    input logic [SAMPLE_W-1:0] left_word,
    input logic [SAMPLE_W-1:0] right_word,
    input logic                tick,
    input logic                bclk_s,
    input logic                pol,
    input logic                bit_we,
    input logic [IDX_W-1:0]    bit_idx,
    input logic [LEN_W-1:0]    wl
);

    // R1: one cycle after reset is sampled, outputs are cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (left_word == '0 && right_word == '0 && !frame_valid));

    // R9: the frame strobe never lasts two cycles
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    // R9: the right word only moves together with the strobe
    p_right_with_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> $stable(right_word));

    // R6: a bit is taken only when the bit clock sits at the active level
    p_tick_level_r6: assert property (@(posedge clk) disable iff (rst)
        tick |-> (bclk_s == !pol));

    // R7: a written bit lies inside the latched, clamped word length
    p_idx_bound_r7: assert property (@(posedge clk) disable iff (rst)
        bit_we |-> ({1'b0, bit_idx} < wl && wl >= LEN_W'(MIN_LEN) && wl <= LEN_W'(SAMPLE_W)));

endmodule

bind sar_receiver sar_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .left_word   (left_word),
    .right_word  (right_word),
    .tick        (tick),
    .bclk_s      (bclk_s),
    .pol         (bclk_pol),
    .bit_we      (bit_we),
    .bit_idx     (bit_idx),
    .wl          (cur_wl)
);

// File: tb/sar_receiver_bench.sv
module sar_receiver_bench;
    import sar_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk   = 1'b0;
    logic             rst   = 1'b1;
    logic             bclk  = 1'b0;
    logic             lrclk = 1'b0;
    logic             wclk  = 1'b0;
    logic             sdata = 1'b0;
    logic [1:0]       fmt   = 2'b00;
    logic             pol   = 1'b0;
    logic [LEN_W-1:0] wlen  = LEN_W'(16);
    logic [15:0]      left_word;
    logic [15:0]      right_word;
    logic             frame_valid;

    int          checks  = 0;
    int          fails   = 0;
    int          strobes = 0;
    logic [15:0] cap_l   = '0;
    logic [15:0] cap_r   = '0;
    bit          gate_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_receiver u_sar_receiver (
        .clk         (clk),
        .rst         (rst),
        .bclk_in     (bclk),
        .lrclk_in    (lrclk),
        .wclk_in     (wclk),
        .sdata_in    (sdata),
        .fmt_sel     (fmt),
        .bclk_pol    (pol),
        .word_len    (wlen),
        .left_word   (left_word),
        .right_word  (right_word),
        .frame_valid (frame_valid)
    );

    always @(negedge clk) begin
        if (!rst && frame_valid) begin
            strobes = strobes + 1;
            cap_l   = left_word;
            cap_r   = right_word;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bench_len(input int req);
        if (req < 4)  return 4;
        if (req > 16) return 16;
        return req;
    endfunction

    function automatic logic [15:0] expect_word(input logic [63:0] stream, input int count,
                                                input int lead, input int wl);
        logic [15:0] w;
        w = '0;
        for (int i = 0; i < wl; i++)
            if (lead + i < count) w[15-i] = stream[63-(lead+i)];
        return w;
    endfunction

    task automatic bit_tick(input logic lr, input logic wc, input logic d);
        @(negedge clk);
        bclk  = pol;
        lrclk = lr;
        wclk  = wc;
        sdata = d;
        repeat (4) @(negedge clk);
        bclk = !pol;
        repeat (4) @(negedge clk);
        if (gate_en) begin
            repeat ($urandom_range(0, 6)) @(negedge clk);
            if ($urandom_range(0, 1) == 1) bclk = pol;
        end
    endtask

    task automatic run_frame(input string tag, input logic [1:0] f, input logic p, input int wreq,
                             input int lcnt, input int rcnt,
                             input logic [63:0] ls, input logic [63:0] rs);
        int lead;
        int wl;
        int fall_l;
        int fall_r;
        @(negedge clk);
        rst   = 1'b1;
        fmt   = f;
        pol   = p;
        wlen  = wreq[LEN_W-1:0];
        bclk  = p;
        lrclk = 1'b0;
        wclk  = 1'b0;
        sdata = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        strobes = 0;
        check({tag, " R1 reset left"}, {16'h0, left_word}, 32'h0);
        check({tag, " R1 reset right"}, {16'h0, right_word}, 32'h0);
        check({tag, " R1 reset strobe"}, {31'h0, frame_valid}, 32'h0);
        bit_tick(1'b0, 1'b0, 1'b0);
        fall_l = (f == 2'b11) ? $urandom_range(1, lcnt - 1) : 0;
        fall_r = (f == 2'b11) ? $urandom_range(1, rcnt - 1) : 0;
        for (int k = 0; k < lcnt; k++) bit_tick(1'b1, k < fall_l, ls[63-k]);
        for (int k = 0; k < rcnt; k++) bit_tick(1'b0, k < fall_r, rs[63-k]);
        bit_tick(1'b1, f == 2'b11, 1'b0);
        repeat (12) @(negedge clk);
        lead = (f == 2'b10) ? 16 : (f == 2'b01) ? 1 : 0;
        wl   = bench_len(wreq);
        check({tag, " R9 strobe count"}, strobes, 1);
        check({tag, " left"}, {16'h0, cap_l}, {16'h0, expect_word(ls, lcnt, lead, wl)});
        check({tag, " right"}, {16'h0, cap_r}, {16'h0, expect_word(rs, rcnt, lead, wl)});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] a;
        logic [63:0] b;
        string       tag;
        void'($urandom(2024));

        a = {$urandom, $urandom};
        b = {$urandom, $urandom};
        gate_en = 1'b0;
        run_frame("R2 R10 packed 32-edge", 2'b00, 1'b0, 16, 16, 16, a, b);
        run_frame("R6 falling edge", 2'b00, 1'b1, 16, 16, 16, b, a);
        run_frame("R3 one-bit delay", 2'b01, 1'b0, 12, 13, 13, a, b);
        run_frame("R4 sixteen delay", 2'b10, 1'b0, 16, 32, 32, b, a);
        run_frame("R4 R7 delay short word", 2'b10, 1'b1, 8, 24, 30, a, b);
        run_frame("R5 word clock", 2'b11, 1'b1, 8, 10, 12, a, b);
        run_frame("R7 minimum length", 2'b00, 1'b0, 4, 20, 20, b, a);
        run_frame("R7 clamp low", 2'b00, 1'b1, 2, 12, 12, a, b);
        run_frame("R7 clamp high", 2'b01, 1'b0, 31, 20, 20, b, a);
        run_frame("R8 cut short", 2'b00, 1'b0, 16, 9, 7, a, b);
        run_frame("R8 cut inside delay", 2'b10, 1'b0, 16, 20, 25, b, a);
        gate_en = 1'b1;
        run_frame("R10 gated", 2'b00, 1'b0, 16, 16, 16, a, b);
        run_frame("R10 R5 gated word clock", 2'b11, 1'b0, 16, 16, 16, b, a);

        for (int n = 0; n < 36; n++) begin
            logic [1:0] f;
            int         wreq;
            int         lead;
            int         lc;
            int         rc;
            f    = 2'($urandom_range(0, 3));
            wreq = $urandom_range(2, 20);
            lead = (f == 2'b10) ? 16 : (f == 2'b01) ? 1 : 0;
            lc   = lead + bench_len(wreq) + $urandom_range(0, 6) - 3;
            rc   = lead + bench_len(wreq) + $urandom_range(0, 6) - 3;
            if (lc < 2) lc = 2;
            if (rc < 2) rc = 2;
            case (f)
                2'b00:   tag = "R2 R10 random";
                2'b01:   tag = "R3 R10 random";
                2'b10:   tag = "R4 R10 random";
                default: tag = "R5 R10 random";
            endcase
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            run_frame(tag, f, 1'($urandom_range(0, 1)), wreq, lc, rc, a, b);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule